// File: doc/BRIEF.md
# Column Counter-Tree Unsigned Multiplier

This block multiplies two 8-bit unsigned operands into a 16-bit product. It first forms all 64 single-bit products `op_a[i] & op_b[j]` at once. It then sums each weight column `k = i + j` with counters whose 3-bit output is the number of ones at their inputs.

The reduction has two counter stages. In stage one, every column is collapsed by a single counter of up to seven inputs. The centre column is the only one with eight terms, and its eighth term skips ahead to stage two. A counter output bit of weight 1 stays in its column, weight 2 moves up one column and weight 4 moves up two. In stage two, every column holds at most four bits, which a 4-input counter collapses again. A final three-row addition then gives the product. Any bit that would land above bit 15 is dropped.

Each counter of four to six inputs is made from two small bit adders whose 2-bit counts are merged by a 3-bit lookahead adder. The 7-input counter is a 4-input counter plus a full adder, merged by the same lookahead adder. By default the product and a valid flag are registered once at the output. A parameter selects a purely combinational output instead.

Top module: `vx_counter_mult`

## Requirements
- R1: For every one of the 65536 operand pairs, `prod` equals `op_a * op_b` as unsigned 16-bit values.
- R2: When `op_a` has only bit i set and `op_b` has only bit j set, `prod` has only bit i+j set. This shows that each column gathers exactly the terms with i + j = k.
- R3: `prod[0]` always equals `op_a[0] & op_b[0]`.
- R4: Each ones counter of width N, for N from 1 to 7, outputs on its 3-bit `cnt` port the binary number of ones among its N inputs, for every input pattern.
- R5: With both operands at 255, `prod` is 16'hFE01, and no carry out of the top column disturbs the 16 bits kept.
- R6: With `REG_OUT=1`, `prod` and `prod_valid` change only at a rising clock edge. They show the product and the `in_valid` value sampled at that edge, and they keep their previous value before it.
- R7: With `REG_OUT=1`, a high `rst` sampled at a rising edge sets `prod` to 0 and `prod_valid` to 0, whatever the other inputs are.
- R8: A zero in either operand gives `prod` equal to 0.
- R9: With `REG_OUT=0`, `prod` follows the operands with no clock, and `prod_valid` follows `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| in_valid | input | 1 | Marks the operands as a valid request |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| prod | output | 16 | Unsigned product |
| prod_valid | output | 1 | Valid flag that accompanies `prod` |

## Verification
The clocked properties check on every cycle that a registered product equals the product of the operands one cycle earlier. They also check that the least significant bit matches the corner AND, that a zero operand yields zero, that the valid flag trails the request by one cycle, and that reset clears both outputs. The counters' own correctness for every input pattern is shown only by the bench, which drives each counter width directly. The bench also covers the one-hot routing of single terms to their columns, the exhaustive sweep of all operand pairs, and the unclocked behaviour of the combinational variant.

// File: rtl/vxm_pkg.sv
`timescale 1ns/1ps
package vxm_pkg;
  localparam int OPW    = 8;            // operand width
  localparam int PW     = 2 * OPW;      // product width
  localparam int NCOL   = 2 * OPW - 1;  // columns that hold partial products
  localparam int MAXCNT = 7;            // widest counter in the library
  localparam int CNTW   = 3;            // counter output width

  typedef logic [CNTW-1:0] cnt3_t;

  // lowest row index i that contributes to column k
  function automatic int col_lo(input int k);
    return (k > OPW - 1) ? k - (OPW - 1) : 0;
  endfunction

  // number of partial products that land in column k
  function automatic int col_height(input int k);
    int hi;
    hi = (k < OPW - 1) ? k : OPW - 1;
    return hi - col_lo(k) + 1;
  endfunction
endpackage

// File: rtl/mul_bit_adder.sv
`timescale 1ns/1ps
// Adds one to three single-bit inputs into a 2-bit count (wire, half or full adder).
module mul_bit_adder #(
  parameter int N = 3
) (
  input  logic [N-1:0] x,
  output logic [1:0]   s
);
  if (N == 1) begin : g_one
    assign s = {1'b0, x[0]};
  end else if (N == 2) begin : g_half
    assign s = {x[0] & x[1], x[0] ^ x[1]};
  end else begin : g_full
    assign s = {(x[0] & x[1]) | (x[2] & (x[0] ^ x[1])), ^x};
  end
endmodule

// File: rtl/mul_cla3.sv
`timescale 1ns/1ps
// 3-bit adder with lookahead carries; the sum never exceeds 7 where it is used.
module mul_cla3 (
  input  logic [2:0] a,
  input  logic [2:0] b,
  output logic [2:0] s
);
  logic [2:0] g, p, c;
  assign g = a & b;
  assign p = a ^ b;
  assign c = {g[1] | (p[1] & g[0]), g[0], 1'b0};
  assign s = p ^ c;
endmodule

// File: rtl/mul_ones_counter.sv
`timescale 1ns/1ps
// N-input counter of ones (N = 1..7), output is the binary count.
module mul_ones_counter
  import vxm_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] x,
  output cnt3_t        cnt
);
  if (N <= 3) begin : g_small
    logic [1:0] s;
    mul_bit_adder #(.N(N)) u_add (.x(x), .s(s));
    assign cnt = {1'b0, s};
  end else if (N <= 6) begin : g_pair
    localparam int NA = (N + 1) / 2;
    localparam int NB = N - NA;
    logic [1:0] sa, sb;
    mul_bit_adder #(.N(NA)) u_lo (.x(x[NA-1:0]), .s(sa));
    mul_bit_adder #(.N(NB)) u_hi (.x(x[N-1:NA]), .s(sb));
    mul_cla3 u_merge (.a({1'b0, sa}), .b({1'b0, sb}), .s(cnt));
  end else begin : g_seven
    // a 4-input counter plus a full adder, merged by the lookahead adder
    logic [1:0] q0, q1, sf;
    cnt3_t      c4;
    mul_bit_adder #(.N(2)) u_q0 (.x(x[1:0]), .s(q0));
    mul_bit_adder #(.N(2)) u_q1 (.x(x[3:2]), .s(q1));
    mul_cla3 u_four (.a({1'b0, q0}), .b({1'b0, q1}), .s(c4));
    mul_bit_adder #(.N(3)) u_fa (.x(x[6:4]), .s(sf));
    mul_cla3 u_merge (.a(c4), .b({1'b0, sf}), .s(cnt));
  end
endmodule

// File: rtl/vx_counter_mult.sv
`timescale 1ns/1ps
module vx_counter_mult
  import vxm_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [OPW-1:0] op_a,
  input  logic [OPW-1:0] op_b,
  output logic [PW-1:0] prod,
  output logic          prod_valid
);
  // stage-one outputs split by weight, plus the term that skips stage one
  logic [PW-1:0] s1_w0, s1_b1, s1_b2, skip;
  logic [PW-1:0] s1_w1, s1_w2;
  logic [PW-1:0] r0, r1, r2;
  logic [PW-1:0] sum;

  for (genvar k = 0; k < NCOL; k++) begin : g_col
    localparam int LO = col_lo(k);
    localparam int H  = col_height(k);
    localparam int CW = (H > MAXCNT) ? MAXCNT : H;
    logic [OPW-1:0] terms;
    cnt3_t          c;
    for (genvar n = 0; n < OPW; n++) begin : g_pp
      if (n < H) begin : g_on
        assign terms[n] = op_a[LO+n] & op_b[k-LO-n];
      end else begin : g_off
        assign terms[n] = 1'b0;
      end
    end
    mul_ones_counter #(.N(CW)) u_cnt (.x(terms[CW-1:0]), .cnt(c));
    assign s1_w0[k] = c[0];
    assign s1_b1[k] = c[1];
    assign s1_b2[k] = c[2];
    if (H > MAXCNT) begin : g_skip
      assign skip[k] = terms[MAXCNT];
    end else begin : g_noskip
      assign skip[k] = 1'b0;
    end
  end
  assign s1_w0[PW-1] = 1'b0;
  assign s1_b1[PW-1] = 1'b0;
  assign s1_b2[PW-1] = 1'b0;
  assign skip[PW-1]  = 1'b0;

  // move weight-2 and weight-4 bits into the columns they belong to
  assign s1_w1 = {s1_b1[PW-2:0], 1'b0};
  assign s1_w2 = {s1_b2[PW-3:0], 2'b00};

  for (genvar k = 0; k < PW; k++) begin : g_st2
    cnt3_t c2;
    mul_ones_counter #(.N(4)) u_cnt (
      .x  ({skip[k], s1_w0[k], s1_w1[k], s1_w2[k]}),
      .cnt(c2)
    );
    assign r0[k] = c2[0];
    assign r1[k] = c2[1];
    assign r2[k] = c2[2];
  end

  // final addition; anything beyond bit PW-1 is dropped
  assign sum = r0 + {r1[PW-2:0], 1'b0} + {r2[PW-3:0], 2'b00};

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        prod       <= '0;
        prod_valid <= 1'b0;
      end else begin
        prod       <= sum;
        prod_valid <= in_valid;
      end
    end
  end else begin : g_comb
    assign prod       = sum;
    assign prod_valid = in_valid;
  end
endmodule

// File: rtl/vx_counter_mult_chk.sv
`timescale 1ns/1ps
module vx_counter_mult_chk
  import vxm_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [OPW-1:0] op_a,
  input logic [OPW-1:0] op_b,
  input logic [PW-1:0]  prod,
  input logic           prod_valid
);
  logic [PW-1:0] ext_a, ext_b;
  assign ext_a = {{OPW{1'b0}}, op_a};
  assign ext_b = {{OPW{1'b0}}, op_b};

  if (REG_OUT) begin : g_reg_props
    // R1: registered product equals the product of last cycle's operands
    p_product_r1: assert property (@(posedge clk) disable iff (rst)
      prod_valid |-> prod == $past(ext_a) * $past(ext_b));

    // R3: least significant bit is the corner AND term
    p_lsb_r3: assert property (@(posedge clk) disable iff (rst)
      prod_valid |-> prod[0] == ($past(op_a[0]) & $past(op_b[0])));

    // R8: a zero operand gives a zero product
    p_zero_r8: assert property (@(posedge clk) disable iff (rst)
      (prod_valid && ($past(op_a) == '0 || $past(op_b) == '0)) |-> prod == '0);

    // R6: the valid flag trails the request by one cycle
    p_valid_rise_r6: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> prod_valid);
    p_valid_fall_r6: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !prod_valid);

    // R7: synchronous reset clears both outputs
    p_reset_clear_r7: assert property (@(posedge clk)
      rst |=> (prod == '0 && !prod_valid));
  end
endmodule

bind vx_counter_mult vx_counter_mult_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .prod      (prod),
  .prod_valid(prod_valid)
);

// File: tb/vx_counter_mult_test.sv
`timescale 1ns/1ps
module vx_counter_mult_test;
  localparam int WD_CYCLES = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  op_a = '0;
  logic [7:0]  op_b = '0;
  logic [15:0] prod, prod_c;
  logic        prod_valid, prod_valid_c;
  logic [6:0]  pat = '0;
  logic [2:0]  cnt_o [1:7];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vx_counter_mult #(.REG_OUT(1'b1)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .prod(prod), .prod_valid(prod_valid)
  );

  vx_counter_mult #(.REG_OUT(1'b0)) uut_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .prod(prod_c), .prod_valid(prod_valid_c)
  );

  for (genvar n = 1; n <= 7; n++) begin : g_cnt
    mul_ones_counter #(.N(n)) u_c (.x(pat[n-1:0]), .cnt(cnt_o[n]));
  end

  function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    return {8'b0, a} * {8'b0, b};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // drive at the falling edge, check the combinational copy, then the registered one
  task automatic run_pair(input string tag, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    op_a = a; op_b = b; in_valid = 1'b1;
    #1;
    check({tag, " R9 comb"}, prod_c, ref_mul(a, b));
    @(posedge clk);
    #1;
    check(tag, prod, ref_mul(a, b));
    check({tag, " R6 valid"}, {15'b0, prod_valid}, 16'd1);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));

    // R7: reset held with live inputs keeps outputs cleared
    @(negedge clk);
    op_a = 8'hA5; op_b = 8'h3C; in_valid = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R7 reset prod", prod, 16'h0000);
    check("R7 reset valid", {15'b0, prod_valid}, 16'd0);

    @(negedge clk);
    rst = 1'b0;

    // R4: every counter width against a ones count, every pattern
    for (int p = 0; p < 128; p++) begin
      pat = 7'(p);
      #1;
      for (int n = 1; n <= 7; n++) begin
        check($sformatf("R4 counter N=%0d pat=%0d", n, p), {13'b0, cnt_o[n]},
              16'($countones(pat & 7'((1 << n) - 1))));
      end
    end

    // R1: exhaustive sweep of all operand pairs
    for (int ia = 0; ia < 256; ia++) begin
      for (int ib = 0; ib < 256; ib++) begin
        run_pair("R1 exhaustive", 8'(ia), 8'(ib));
      end
    end

    // R2: one-hot operands land in column i+j
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        run_pair("R2 onehot", 8'(1 << i), 8'(1 << j));
        check("R2 single column", prod, 16'(1 << (i + j)));
      end
    end

    // R5: largest operands
    run_pair("R5 max", 8'hFF, 8'hFF);
    check("R5 max value", prod, 16'hFE01);

    // R8: zero operands
    run_pair("R8 zero a", 8'h00, 8'hFF);
    check("R8 zero a value", prod, 16'h0000);
    run_pair("R8 zero b", 8'hB7, 8'h00);
    check("R8 zero b value", prod, 16'h0000);

    // R1/R3: seeded random pairs
    for (int t = 0; t < 2000; t++) begin
      logic [7:0] ra, rb;
      ra = 8'($urandom);
      rb = 8'($urandom);
      run_pair("R1 random", ra, rb);
      check("R3 lsb", {15'b0, prod[0]}, {15'b0, ra[0] & rb[0]});
    end

    // R6: outputs hold until the edge, valid follows a low request
    run_pair("R6 setup", 8'd13, 8'd11);
    @(negedge clk);
    op_a = 8'd200; op_b = 8'd3; in_valid = 1'b0;
    #1;
    check("R6 hold before edge", prod, 16'd143);
    check("R6 valid hold before edge", {15'b0, prod_valid}, 16'd1);
    check("R9 comb valid low", {15'b0, prod_valid_c}, 16'd0);
    @(posedge clk);
    #1;
    check("R6 after edge", prod, 16'd600);
    check("R6 valid low after edge", {15'b0, prod_valid}, 16'd0);

    // R7: mid-run reset
    @(negedge clk);
    op_a = 8'hEE; op_b = 8'h77; in_valid = 1'b1; rst = 1'b1;
    @(posedge clk);
    #1;
    check("R7 midrun prod", prod, 16'h0000);
    check("R7 midrun valid", {15'b0, prod_valid}, 16'd0);
    @(negedge clk);
    rst = 1'b0;
    run_pair("R7 recover", 8'hEE, 8'h77);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule